// File: doc/BRIEF.md
# Toggle-Write Interrupt Status Router

This block collects internal trigger events of a multi-threaded core into one status word. Each bit belongs to one source. A hardware event sets its bit. Software changes bits by writing a toggle mask: every 1 in the written word inverts the matching status bit, and every 0 leaves its bit alone. The block has no separate mask register. An interrupt is raised only on a 0-to-1 transition of a status bit. A bit that stays set raises nothing new, so software retriggers a pending source by toggling it off and then on again.

Two sources can be routed to a thread: performance trigger 0 at status bit 16 and performance trigger 1 at status bit 17. Each has its own vector register. A vector value of 0 leaves the source unrouted, which is how software masks it. A value of n+1 routes the source to hardware thread n. Each thread has an active-low, level-sensitive trigger output. That output goes low on a routed rising edge. It returns high when software writes the status register and no routed, set bit still targets that thread.

The bus is a plain single-cycle register port. Byte address 0x00 holds the status word, 0x08 holds the vector for bit 16 and 0x10 holds the vector for bit 17.

Top module: `trig_status_router`

## Requirements
- R1: After reset the status word and both vectors are 0, every trigN bit is 1, and reads of all three registers return 0.
- R2: A write to address 0x00 inverts each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged. The new value is readable in the cycle after the write edge.
- R3: A 1 on hwEvent[b] sets status bit b at the next clock edge. When a toggle write and a hardware event hit the same bit in the same cycle, the bit ends up set.
- R4: When status bit 16 (or 17) goes from 0 to 1 while its vector holds n+1, trigN[n] is 0 from the cycle after that edge.
- R5: A routed bit that is already 1 raises no trigger when it is set again, or when its vector is changed. Toggling it to 0 and back to 1 raises the trigger again.
- R6: With a vector value of 0, its source bit still updates but no trigN bit changes.
- R7: A low trigN[n] returns to 1 only at a status write after which no set routed bit targets thread n. A status write that leaves such a bit set keeps trigN[n] low.
- R8: Status bits other than 16 and 17 never affect trigN.
- R9: The two routed sources act independently. Vector registers are at 0x08 (bit 16) and 0x10 (bit 17), each holding its value in write-data bits [2:0], and they read back the value last written.
- R10: Reads have no side effects. Any address other than 0x00, 0x08 and 0x10 reads as 0, and writes to it change no state.
- R11: Vector values above the thread count (5 to 7 with four threads) route the source to no thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data (toggle mask or vector value) |
| busRdata | output | 32 | Read data for busAddr, combinational |
| hwEvent | input | 32 | Hardware event inputs, one per status bit |
| trigN | output | 4 | Per-thread trigger, active low |

## Verification
A vector table drives mixed toggle masks, all-zero masks, all-ones masks, hardware events alone, and a toggle and an event on the same bit. Together these separate a true XOR from set, clear or overwrite, and show that the event wins the race. Directed sequences then test the routing. A single routed edge shows the fire timing. A second event on a bit that is already set, and a vector change while the bit is set, show that only edges fire. Toggling off and then on shows retriggering. A status write with the routed bit left set shows that the output stays low. Two sources aimed at different threads show their independence. Unrouted, out-of-range and non-routable bits confirm that the outputs do not move, and unmapped addresses plus reset round off the port-level checks.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_VEC0 = 2'd2,
    RD_VEC1 = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic                 wrStat;
    logic [NUM_SRC-1:0]   wrVec;
    rd_sel_e              rdSel;
  } tsr_strobe_t;

endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  STAT_ADDR = 8'h00,
  parameter logic [7:0]  VEC0_ADDR = 8'h08,
  parameter logic [7:0]  VEC1_ADDR = 8'h10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output tsr_strobe_t       strobe
);

  logic hitStat, hitVec0, hitVec1;

  always_comb begin
    hitStat = (busAddr == ADDR_W'(STAT_ADDR));
    hitVec0 = (busAddr == ADDR_W'(VEC0_ADDR));
    hitVec1 = (busAddr == ADDR_W'(VEC1_ADDR));

    strobe.wrStat   = busWe && hitStat;
    strobe.wrVec[0] = busWe && hitVec0;
    strobe.wrVec[1] = busWe && hitVec1;

    if (hitStat)      strobe.rdSel = RD_STAT;
    else if (hitVec0) strobe.rdSel = RD_VEC0;
    else if (hitVec1) strobe.rdSel = RD_VEC1;
    else              strobe.rdSel = RD_NONE;
  end

endmodule

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int STAT_W   = 32,
  parameter int NUM_THR  = 4,
  parameter int VEC_W    = 3,
  parameter int SRC0_BIT = 16,
  parameter int SRC1_BIT = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  tsr_strobe_t        strobe,
  input  logic [STAT_W-1:0]  busWdata,
  input  logic [STAT_W-1:0]  hwEvent,
  output logic [STAT_W-1:0]  busRdata,
  output logic [NUM_THR-1:0] trigN,
  output logic [STAT_W-1:0]  statusQ,
  output logic [VEC_W-1:0]   vec0Q,
  output logic [VEC_W-1:0]   vec1Q
);

  localparam int SRC_BIT [NUM_SRC] = '{SRC0_BIT, SRC1_BIT};

  logic [STAT_W-1:0]  toggleMask;
  logic [STAT_W-1:0]  statusNext;
  logic [STAT_W-1:0]  riseVec;
  logic [VEC_W-1:0]   vecQ     [NUM_SRC];
  logic [NUM_SRC-1:0] srcRise;
  logic [NUM_SRC-1:0] srcLevel;
  logic [NUM_THR-1:0] pendQ;

  // Status update: toggle by software, then hardware events force set.
  always_comb begin
    toggleMask = strobe.wrStat ? busWdata : '0;
    statusNext = (statusQ ^ toggleMask) | hwEvent;
    riseVec    = statusNext & ~statusQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusNext;
  end

  // One vector register per routable source.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              vecQ[s] <= '0;
      else if (strobe.wrVec[s]) vecQ[s] <= busWdata[VEC_W-1:0];
    end
    assign srcRise[s]  = riseVec[SRC_BIT[s]];
    assign srcLevel[s] = statusNext[SRC_BIT[s]];
  end

  // Per-thread trigger hold: set on a routed edge, released by a status
  // write that leaves no routed set bit aimed at the thread.
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic setHit, holdHit;
    always_comb begin
      setHit  = 1'b0;
      holdHit = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (vecQ[s] == VEC_W'(t + 1)) begin
          setHit  = setHit  | srcRise[s];
          holdHit = holdHit | srcLevel[s];
        end
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         pendQ[t] <= 1'b0;
      else if (setHit)                   pendQ[t] <= 1'b1;
      else if (strobe.wrStat && !holdHit) pendQ[t] <= 1'b0;
    end
  end

  assign trigN = ~pendQ;
  assign vec0Q = vecQ[0];
  assign vec1Q = vecQ[1];

  always_comb begin
    unique case (strobe.rdSel)
      RD_STAT: busRdata = statusQ;
      RD_VEC0: busRdata = STAT_W'(vecQ[0]);
      RD_VEC1: busRdata = STAT_W'(vecQ[1]);
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/trig_status_router.sv
module trig_status_router
  import tsr_pkg::*;
#(
  parameter int          STAT_W    = 32,
  parameter int          NUM_THR   = 4,
  parameter int          ADDR_W    = 8,
  parameter int          SRC0_BIT  = 16,
  parameter int          SRC1_BIT  = 17,
  parameter logic [7:0]  STAT_ADDR = 8'h00,
  parameter logic [7:0]  VEC0_ADDR = 8'h08,
  parameter logic [7:0]  VEC1_ADDR = 8'h10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [STAT_W-1:0]  busWdata,
  output logic [STAT_W-1:0]  busRdata,
  input  logic [STAT_W-1:0]  hwEvent,
  output logic [NUM_THR-1:0] trigN
);

  localparam int VEC_W = $clog2(NUM_THR + 1);

  tsr_strobe_t       strobe;
  logic [STAT_W-1:0] statusQ;
  logic [VEC_W-1:0]  vec0Q;
  logic [VEC_W-1:0]  vec1Q;

  tsr_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .VEC0_ADDR(VEC0_ADDR), .VEC1_ADDR(VEC1_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strobe(strobe)
  );

  tsr_datapath #(
    .STAT_W(STAT_W), .NUM_THR(NUM_THR), .VEC_W(VEC_W),
    .SRC0_BIT(SRC0_BIT), .SRC1_BIT(SRC1_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .busWdata(busWdata), .hwEvent(hwEvent),
    .busRdata(busRdata), .trigN(trigN),
    .statusQ(statusQ), .vec0Q(vec0Q), .vec1Q(vec1Q)
  );

endmodule

// File: rtl/tsr_chk.sv
module tsr_chk #(
  parameter int          STAT_W    = 32,
  parameter int          NUM_THR   = 4,
  parameter int          ADDR_W    = 8,
  parameter int          VEC_W     = 3,
  parameter int          SRC0_BIT  = 16,
  parameter int          SRC1_BIT  = 17,
  parameter logic [7:0]  STAT_ADDR = 8'h00,
  parameter logic [7:0]  VEC0_ADDR = 8'h08,
  parameter logic [7:0]  VEC1_ADDR = 8'h10
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [STAT_W-1:0]  hwEvent,
  input logic [NUM_THR-1:0] trigN,
  input logic [STAT_W-1:0]  statusQ,
  input logic [VEC_W-1:0]   vec0Q,
  input logic [VEC_W-1:0]   vec1Q
);

  logic unmapped;
  assign unmapped = (busAddr != ADDR_W'(STAT_ADDR)) &&
                    (busAddr != ADDR_W'(VEC0_ADDR)) &&
                    (busAddr != ADDR_W'(VEC1_ADDR));

  // R3
  hw_sets_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwEvent != '0) |=> ((statusQ & $past(hwEvent)) == $past(hwEvent)));

  // R2
  idle_holds_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWe && hwEvent == '0) |=> $stable(statusQ));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && unmapped && hwEvent == '0) |=>
      ($stable(statusQ) && $stable(vec0Q) && $stable(vec1Q)));

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    // R4
    edge_fires_chk: assert property (@(posedge clk) disable iff (!rstN)
      (($rose(statusQ[SRC0_BIT]) && $past(vec0Q) == VEC_W'(t + 1)) ||
       ($rose(statusQ[SRC1_BIT]) && $past(vec1Q) == VEC_W'(t + 1))) |-> !trigN[t]);

    // R7
    release_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(trigN[t]) |-> $past(busWe && busAddr == ADDR_W'(STAT_ADDR)));

    // R6
    fall_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(trigN[t]) |->
        (($rose(statusQ[SRC0_BIT]) && $past(vec0Q) == VEC_W'(t + 1)) ||
         ($rose(statusQ[SRC1_BIT]) && $past(vec1Q) == VEC_W'(t + 1))));
  end

endmodule

bind trig_status_router tsr_chk #(
  .STAT_W(STAT_W), .NUM_THR(NUM_THR), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
  .SRC0_BIT(SRC0_BIT), .SRC1_BIT(SRC1_BIT), .STAT_ADDR(STAT_ADDR),
  .VEC0_ADDR(VEC0_ADDR), .VEC1_ADDR(VEC1_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .hwEvent(hwEvent), .trigN(trigN), .statusQ(statusQ),
  .vec0Q(vec0Q), .vec1Q(vec1Q)
);

// File: tb/sim_trig_status_router.sv
module sim_trig_status_router;

  localparam time CLK_P = 5ns;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] hw;
    logic [31:0] expStat;
  } step_t;

  // R2 / R3 / R10 vector table (vectors unrouted, triggers stay high)
  localparam step_t TBL [8] = '{
    '{1'b1, 8'h00, 32'h0000_00FF, 32'h0000_0000, 32'h0000_00FF},
    '{1'b1, 8'h00, 32'h0000_000F, 32'h0000_0000, 32'h0000_00F0},
    '{1'b1, 8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_00F0},
    '{1'b0, 8'h00, 32'h0000_0000, 32'h8000_0001, 32'h8000_00F1},
    '{1'b1, 8'h00, 32'h8000_0001, 32'h0000_0001, 32'h0000_00F1},
    '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_00F1},
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FF0E},
    '{1'b1, 8'h00, 32'hFFFF_FF0E, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] hwEvent = '0;
  logic [3:0]  trigN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  trig_status_router u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .hwEvent(hwEvent),
    .trigN(trigN)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a falling edge, return at the next
  // falling edge with the address parked on the status register.
  task automatic step(logic we, logic [7:0] addr, logic [31:0] wd, logic [31:0] hw);
    busWe = we; busAddr = addr; busWdata = wd; hwEvent = hw;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'h00; busWdata = '0; hwEvent = '0;
    #1;
  endtask

  task automatic rd(logic [7:0] addr, output logic [31:0] val);
    busAddr = addr;
    #1 val = busRdata;
    busAddr = 8'h00;
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic chkReset();
    logic [31:0] v;
    chk("R1 trigN", 32'(trigN), 32'hF);
    rd(8'h00, v); chk("R1 status", v, 32'h0);
    rd(8'h08, v); chk("R1 vec0", v, 32'h0);
    rd(8'h10, v); chk("R1 vec1", v, 32'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    @(negedge clk);
    doReset();
    chkReset();

    // Table walk: R2 toggling, R3 event priority, R10 unmapped write
    for (int i = 0; i < 8; i++) begin
      step(TBL[i].we, TBL[i].addr, TBL[i].wd, TBL[i].hw);
      chk($sformatf("R2/R3 table step %0d status", i), busRdata, TBL[i].expStat);
      chk($sformatf("R8 table step %0d trigN", i), 32'(trigN), 32'hF);
    end

    // Route bit 16 to thread 0
    step(1, 8'h08, 32'h1, 0);
    rd(8'h08, v); chk("R9 vec0 readback", v, 32'h1);
    step(0, 8'h00, 0, 32'h0001_0000);
    chk("R4 edge fires thread0", 32'(trigN), 32'hE);
    step(0, 8'h00, 0, 32'h0001_0000);
    chk("R5 repeat event no change", 32'(trigN), 32'hE);
    step(1, 8'h00, 32'h1, 0);
    chk("R7 write keeps low while set", 32'(trigN), 32'hE);
    step(1, 8'h00, 32'h0001_0000, 0);
    chk("R7 release after clear", 32'(trigN), 32'hF);
    step(1, 8'h00, 32'h0001_0000, 0);
    chk("R5 retrigger by toggle", 32'(trigN), 32'hE);
    step(1, 8'h00, 32'h0001_0001, 0);
    chk("R7 release", 32'(trigN), 32'hF);
    chk("R2 status cleared", busRdata, 32'h0);

    // Unrouted source
    step(1, 8'h08, 32'h0, 0);
    step(0, 8'h00, 0, 32'h0001_0000);
    chk("R6 unrouted no trigger", 32'(trigN), 32'hF);
    chk("R6 unrouted status set", busRdata, 32'h0001_0000);
    step(1, 8'h08, 32'h1, 0);
    chk("R5 routing set bit no fire", 32'(trigN), 32'hF);
    step(0, 8'h00, 0, 32'h0001_0000);
    chk("R5 set bit again no fire", 32'(trigN), 32'hF);
    step(1, 8'h00, 32'h0001_0000, 0);
    step(1, 8'h00, 32'h0001_0000, 0);
    chk("R5 retrigger after toggle pair", 32'(trigN), 32'hE);
    step(1, 8'h00, 32'h0001_0000, 0);
    chk("R7 released", 32'(trigN), 32'hF);

    // Two sources to different threads
    step(1, 8'h08, 32'h2, 0);
    step(1, 8'h10, 32'h4, 0);
    rd(8'h10, v); chk("R9 vec1 readback", v, 32'h4);
    step(0, 8'h00, 0, 32'h0003_0000);
    chk("R9 both sources fire", 32'(trigN), 32'h5);
    step(1, 8'h00, 32'h0002_0000, 0);
    chk("R9 thread3 released alone", 32'(trigN), 32'hD);
    step(1, 8'h00, 32'h0001_0000, 0);
    chk("R9 thread1 released", 32'(trigN), 32'hF);

    // Non-routable bits
    step(1, 8'h10, 32'h1, 0);
    step(0, 8'h00, 0, 32'h0004_0020);
    chk("R8 other bits no trigger", 32'(trigN), 32'hF);
    chk("R8 other bits status", busRdata, 32'h0004_0020);
    step(1, 8'h00, 32'h0004_0020, 0);

    // Out-of-range vector
    step(1, 8'h08, 32'h5, 0);
    rd(8'h08, v); chk("R11 vec0 readback", v, 32'h5);
    step(1, 8'h00, 32'h0001_0000, 0);
    chk("R11 out-of-range routes nowhere", 32'(trigN), 32'hF);
    step(1, 8'h00, 32'h0001_0000, 0);

    // Unmapped reads, no read side effect
    step(0, 8'h00, 0, 32'h0000_00A5);
    rd(8'h04, v); chk("R10 unmapped read 0x04", v, 32'h0);
    rd(8'h18, v); chk("R10 unmapped read 0x18", v, 32'h0);
    rd(8'h00, v); rd(8'h00, v2);
    chk("R10 read no side effect", v2, 32'h0000_00A5);
    chk("R10 read value", v, 32'h0000_00A5);
    step(1, 8'h00, 32'h0000_00A5, 0);

    // Same-cycle toggle and event on a routed bit
    step(1, 8'h08, 32'h3, 0);
    step(1, 8'h00, 32'h0001_0000, 32'h0001_0000);
    chk("R3 race event wins status", busRdata, 32'h0001_0000);
    chk("R3 race event fires thread2", 32'(trigN), 32'hB);

    // Reset mid-run
    doReset();
    chkReset();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule